// File: doc/BRIEF.md
# Call and Return Stack Sequencer

This block carries out the stack side of subroutine linkage for a small 8-bit processor core. It owns the stack pointer and drives a single-port on-chip RAM, one byte per cycle. The stack grows upward. A write first advances the pointer and then stores at the new location. A read first fetches at the current location and then steps the pointer back.

Commands arrive on a valid/ready channel and come in five kinds. A call stores a 16-bit return address. A return and an interrupt return restore one. A push stores a single byte and a pop retrieves one. On a call the return address goes to RAM least significant byte first, and on a return it comes back most significant byte first, so the two orders mirror each other.

Results leave on a second valid/ready channel. The channel carries the restored or echoed address together with the popped or pushed byte. The consumer may hold the response back with `rsp_ready` low as long as it likes. While it does, the response stays valid and unchanged and no new command is taken. The command channel accepts only while the sequencer is idle, so `cmd_ready` is the complement of `busy`.

Top module: `stk_seq`

## Requirements
- R1: After reset the stack pointer `sp` is 0x07, `busy`, `rsp_valid` and `irq_release` are low and `cmd_ready` is high.
- R2: A push (op code 2) raises `sp` by one and then writes `cmd_byte` to RAM at the new `sp` with a single write. The response carries that byte on `rsp_byte`.
- R3: A pop (op code 3) issues a single read at the current `sp` and then lowers `sp` by one. The byte read is returned on `rsp_byte`.
- R4: A call (op code 0) writes `cmd_pc[7:0]` at `sp`+1 and then `cmd_pc[15:8]` at `sp`+2. It leaves `sp` two higher and echoes `cmd_pc` on `rsp_pc`.
- R5: A return (op code 1) reads the high byte at `sp` and then the low byte at `sp`-1. It leaves `sp` two lower and returns {high, low} on `rsp_pc`.
- R6: An interrupt return (op code 4) behaves as R5 and raises `irq_release` for exactly one cycle, the first cycle of `rsp_valid`. No other op code raises it.
- R7: `sp` wraps modulo 256 in both directions, and RAM addresses wrap with it.
- R8: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only when `busy` is low. For op codes 0 to 4, `busy` stays high from the cycle after acceptance until the cycle after the response handshake.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_pc` and `rsp_byte` hold their values.
- R10: Op codes 5, 6 and 7 are accepted and dropped. They cause no RAM access, no change of `sp` and no response.
- R11: `mem_we` and `mem_re` are never high together and are both low while idle. Read data is taken from `mem_rdata` one cycle after `mem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this edge when valid |
| cmd_op | input | 3 | 0 call, 1 return, 2 push, 3 pop, 4 interrupt return |
| cmd_pc | input | 16 | Return address for a call |
| cmd_byte | input | 8 | Byte for a push |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pc | output | 16 | Restored or echoed address |
| rsp_byte | output | 8 | Popped or pushed byte |
| busy | output | 1 | Command in progress |
| irq_release | output | 1 | One-cycle pulse closing an interrupt return |
| sp | output | 8 | Current stack pointer |
| mem_addr | output | 8 | RAM address |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_re` |

## Verification
The properties assume that reset is asserted before the first command. They also assume that the RAM answers a read on the cycle after `mem_re`, which is the only way the response contents relate to stored bytes. The stimulus holds `cmd_op`, `cmd_pc` and `cmd_byte` steady while `cmd_valid` waits for acceptance, and it keeps the RAM model at exactly one cycle of read latency. It drives `rsp_ready` low at random, so the hold-under-back-pressure property sees stalls of varying length. Random op codes include the dropped values, and a directed walk takes `sp` through 0xFF to 0x00 so that the wrap behaviour of both pointer directions is covered.

// File: rtl/stk_pkg.sv
package stk_pkg;

  // command codes seen on cmd_op
  typedef enum logic [2:0] {
    OP_CALL = 3'd0,
    OP_RET  = 3'd1,
    OP_PUSH = 3'd2,
    OP_POP  = 3'd3,
    OP_RETI = 3'd4
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RDA,
    ST_RDD,
    ST_RESP
  } stk_state_e;

  function automatic logic op_writes(input logic [2:0] op);
    return (op == OP_CALL) || (op == OP_PUSH);
  endfunction

  function automatic logic op_reads(input logic [2:0] op);
    return (op == OP_RET) || (op == OP_RETI) || (op == OP_POP);
  endfunction

  function automatic logic op_wide(input logic [2:0] op);
    return (op == OP_CALL) || (op == OP_RET) || (op == OP_RETI);
  endfunction

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int SP_W   = 8,
  parameter int SP_RST = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            dec,
  output logic [SP_W-1:0] sp
);
  localparam logic [SP_W-1:0] RST_V = SP_W'(SP_RST);

  // free-running modulo arithmetic, no overflow detection
  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= RST_V;
    else if (inc) sp <= sp + 1'b1;
    else if (dec) sp <= sp - 1'b1;
  end
endmodule

// File: rtl/stk_hold.sv
module stk_hold #(
  parameter int PC_W = 16,
  parameter int DW   = 8,
  parameter int IW   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] load_val,
  input  logic            shift,
  input  logic [DW-1:0]   shift_in,
  input  logic [IW-1:0]   sel,
  output logic [PC_W-1:0] hold,
  output logic [DW-1:0]   sel_byte
);
  localparam int NB = PC_W / DW;

  logic [PC_W-1:0] shifted;

  // bytes read back enter at the bottom, so the first read ends up on top
  generate
    if (NB > 1) begin : g_multi
      assign shifted = {hold[PC_W-DW-1:0], shift_in};
    end else begin : g_single
      assign shifted = shift_in;
    end
  endgenerate

  assign sel_byte = hold[sel*DW +: DW];

  always_ff @(posedge clk) begin
    if (!rst_n)     hold <= '0;
    else if (load)  hold <= load_val;
    else if (shift) hold <= shifted;
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int NB = 2,
  parameter int IW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic          rsp_ready,
  output logic          cmd_ready,
  output logic          busy,
  output logic          sp_inc,
  output logic          sp_dec,
  output logic          mem_we,
  output logic          mem_re,
  output logic          hold_load,
  output logic          hold_shift,
  output logic [IW-1:0] idx,
  output logic          rsp_valid,
  output logic          irq_release
);
  localparam logic [IW-1:0] LAST_WIDE = IW'(NB - 1);

  stk_state_e  state_q;
  logic [2:0]  op_q;
  logic [IW-1:0] cnt_q, lim_q;
  logic        rel_q;
  logic        accept, last;

  assign accept = (state_q == ST_IDLE) && cmd_valid;
  assign last   = (cnt_q == lim_q);

  always_comb begin
    cmd_ready   = (state_q == ST_IDLE);
    busy        = (state_q != ST_IDLE);
    sp_inc      = (accept && op_writes(cmd_op)) || ((state_q == ST_WR) && !last);
    sp_dec      = (state_q == ST_RDA);
    mem_we      = (state_q == ST_WR);
    mem_re      = (state_q == ST_RDA);
    hold_load   = accept;
    hold_shift  = (state_q == ST_RDD);
    idx         = cnt_q;
    rsp_valid   = (state_q == ST_RESP);
    irq_release = rel_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
      lim_q   <= '0;
      rel_q   <= 1'b0;
    end else begin
      rel_q <= (state_q == ST_RDD) && last && (op_q == OP_RETI);
      unique case (state_q)
        ST_IDLE: if (accept) begin
          op_q  <= cmd_op;
          cnt_q <= '0;
          lim_q <= op_wide(cmd_op) ? LAST_WIDE : '0;
          if (op_writes(cmd_op))     state_q <= ST_WR;
          else if (op_reads(cmd_op)) state_q <= ST_RDA;
        end
        ST_WR: begin
          if (last) state_q <= ST_RESP;
          else      cnt_q   <= cnt_q + 1'b1;
        end
        ST_RDA: state_q <= ST_RDD;
        ST_RDD: begin
          if (last) state_q <= ST_RESP;
          else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_RDA;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int SP_W   = 8,
  parameter int PC_W   = 16,
  parameter int DW     = 8,
  parameter int SP_RST = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [2:0]      cmd_op,
  input  logic [PC_W-1:0] cmd_pc,
  input  logic [DW-1:0]   cmd_byte,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PC_W-1:0] rsp_pc,
  output logic [DW-1:0]   rsp_byte,
  output logic            busy,
  output logic            irq_release,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int NB = PC_W / DW;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic          sp_inc, sp_dec, hold_load, hold_shift;
  logic [IW-1:0] idx;
  logic [PC_W-1:0] load_val, hold;
  logic [DW-1:0] sel_byte;

  always_comb begin
    case (cmd_op)
      OP_CALL: load_val = cmd_pc;
      OP_PUSH: load_val = PC_W'(cmd_byte);
      default: load_val = '0;
    endcase
  end

  stk_ctrl #(.NB(NB), .IW(IW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .rsp_ready(rsp_ready), .cmd_ready(cmd_ready), .busy(busy),
    .sp_inc(sp_inc), .sp_dec(sp_dec), .mem_we(mem_we), .mem_re(mem_re),
    .hold_load(hold_load), .hold_shift(hold_shift), .idx(idx),
    .rsp_valid(rsp_valid), .irq_release(irq_release)
  );

  stk_ptr #(.SP_W(SP_W), .SP_RST(SP_RST)) u_ptr (
    .clk(clk), .rst_n(rst_n), .inc(sp_inc), .dec(sp_dec), .sp(sp)
  );

  stk_hold #(.PC_W(PC_W), .DW(DW), .IW(IW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .load_val(load_val),
    .shift(hold_shift), .shift_in(mem_rdata), .sel(idx),
    .hold(hold), .sel_byte(sel_byte)
  );

  assign mem_addr  = sp;
  assign mem_wdata = sel_byte;
  assign rsp_pc    = hold;
  assign rsp_byte  = hold[DW-1:0];
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk #(
  parameter int SP_W = 8,
  parameter int PC_W = 16,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [2:0]      cmd_op,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PC_W-1:0] rsp_pc,
  input logic [DW-1:0]   rsp_byte,
  input logic            busy,
  input logic            irq_release,
  input logic [SP_W-1:0] sp,
  input logic            mem_we,
  input logic            mem_re
);
  logic take;
  assign take = cmd_valid && cmd_ready;

  a_r2_push_raises_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op == 3'd2) |=> (sp == SP_W'($past(sp) + 1'b1)));

  a_r3_read_lowers_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (sp == SP_W'($past(sp) - 1'b1)));

  a_r6_release_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    irq_release |-> rsp_valid);

  a_r6_release_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_release |=> !irq_release);

  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op <= 3'd4) |=> busy);

  a_r9_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pc) && $stable(rsp_byte)));

  a_r10_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cmd_op > 3'd4) |=> (!busy && $stable(sp) && !mem_we && !mem_re));

  a_r11_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r11_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
endmodule

bind stk_seq stk_seq_chk #(.SP_W(SP_W), .PC_W(PC_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_pc(rsp_pc), .rsp_byte(rsp_byte), .busy(busy),
  .irq_release(irq_release), .sp(sp), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/stk_seq_tb.sv
`timescale 1ns/1ps
module stk_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [15:0] cmd_pc = '0;
  logic [7:0] cmd_byte = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [15:0] rsp_pc;
  logic [7:0] rsp_byte, sp, mem_addr, mem_wdata;
  logic [7:0] mem_rdata;
  logic busy, irq_release, mem_we, mem_re;

  logic [7:0] ram [256];
  logic [7:0] ref_mem [256];
  logic [7:0] ref_sp;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  stk_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_pc(cmd_pc), .cmd_byte(cmd_byte),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pc(rsp_pc),
    .rsp_byte(rsp_byte), .busy(busy), .irq_release(irq_release), .sp(sp),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] fill(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  // RAM model: one-cycle read latency, filled while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= fill(i);
      mem_rdata <= '0;
    end else begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= ram[mem_addr];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [15:0] pc, input logic [7:0] byt);
    int we_n = 0, re_n = 0, rel_n = 0;
    bit seen = 0, done = 0, both = 0;
    logic [15:0] f_pc; logic [7:0] f_b, old;
    logic legal;
    legal = (op <= 3'd4);
    @(negedge clk);
    chk("R7 sp tracks model", sp, ref_sp);
    cmd_valid = 1'b1; cmd_op = op; cmd_pc = pc; cmd_byte = byt;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R8 busy after accept", busy, legal);
    chk("R8 ready complements busy", cmd_ready, !legal);
    for (int c = 0; c < 60 && !done; c++) begin
      we_n += mem_we; re_n += mem_re; rel_n += irq_release;
      if (mem_we && mem_re) both = 1;
      if (rsp_valid) begin
        if (!seen) begin
          seen = 1; f_pc = rsp_pc; f_b = rsp_byte;
          chk("R6 release on first rsp cycle", irq_release, op == 3'd4);
        end else begin
          chk("R9 rsp_pc held", rsp_pc, f_pc);
          chk("R9 rsp_byte held", rsp_byte, f_b);
        end
        rsp_ready = ($urandom_range(0, 2) != 0);
        done = rsp_ready;
      end
      if (!legal && c >= 6) done = 1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end
    chk("R11 no simultaneous read and write", both, 0);
    if (legal) begin
      chk("R8 busy clears after handshake", busy, 0);
      chk("R6 release pulse count", rel_n, (op == 3'd4) ? 1 : 0);
    end
    case (op)
      3'd0: begin
        ref_mem[8'(ref_sp + 8'd1)] = pc[7:0];
        ref_mem[8'(ref_sp + 8'd2)] = pc[15:8];
        chk("R4 low byte stored at sp+1", ram[8'(ref_sp + 8'd1)], pc[7:0]);
        chk("R4 high byte stored at sp+2", ram[8'(ref_sp + 8'd2)], pc[15:8]);
        ref_sp = ref_sp + 8'd2;
        chk("R4 rsp_pc echo", f_pc, pc);
        chk("R4 two writes", we_n * 16 + re_n, 32);
      end
      3'd1, 3'd4: begin
        old = ref_sp;
        chk(op == 3'd4 ? "R6 restored pc" : "R5 restored pc", f_pc,
            {ref_mem[old], ref_mem[8'(old - 8'd1)]});
        ref_sp = ref_sp - 8'd2;
        chk("R5 two reads", we_n * 16 + re_n, 2);
      end
      3'd2: begin
        ref_sp = ref_sp + 8'd1;
        ref_mem[ref_sp] = byt;
        chk("R2 byte stored at new sp", ram[ref_sp], byt);
        chk("R2 rsp_byte", f_b, byt);
        chk("R2 one write", we_n * 16 + re_n, 16);
      end
      3'd3: begin
        chk("R3 popped byte", f_b, ref_mem[ref_sp]);
        ref_sp = ref_sp - 8'd1;
        chk("R3 one read", we_n * 16 + re_n, 1);
      end
      default: begin
        chk("R10 dropped op: no response", {31'd0, seen}, 0);
        chk("R10 dropped op: no access", we_n + re_n, 0);
      end
    endcase
    chk("R7 sp after command", sp, ref_sp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) ref_mem[i] = fill(i);
    ref_sp = 8'h07;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp reset", sp, 8'h07);
    chk("R1 busy reset", busy, 0);
    chk("R1 ready reset", cmd_ready, 1);
    chk("R1 rsp_valid reset", rsp_valid, 0);
    chk("R1 release reset", irq_release, 0);

    // directed: first push lands at 0x08, pop returns it
    run_cmd(3'd2, 16'h0, 8'hA5);
    chk("R2 first push address", ram[8'h08], 8'hA5);
    run_cmd(3'd3, 16'h0, 8'h00);
    // directed: walk sp down through zero to 0xFE
    for (int i = 0; i < 9; i++) run_cmd(3'd3, 16'h0, 8'h00);
    chk("R7 wrapped below zero", sp, 8'hFE);
    run_cmd(3'd0, 16'hBEEF, 8'h00);
    chk("R7 low byte at 0xFF", ram[8'hFF], 8'hEF);
    chk("R7 high byte at 0x00", ram[8'h00], 8'hBE);
    chk("R7 sp after wrap call", sp, 8'h00);
    run_cmd(3'd4, 16'h0, 8'h00);
    chk("R7 return across wrap", rsp_pc, 16'hBEEF);
    run_cmd(3'd6, 16'h1234, 8'h77);
    run_cmd(3'd1, 16'h0, 8'h00);

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      logic [2:0] op;
      r = $urandom_range(0, 99);
      if (r < 25) op = 3'd0;
      else if (r < 42) op = 3'd1;
      else if (r < 62) op = 3'd2;
      else if (r < 82) op = 3'd3;
      else if (r < 94) op = 3'd4;
      else op = 3'($urandom_range(5, 7));
      run_cmd(op, 16'($urandom), 8'($urandom));
    end

    summary();
    $finish;
  end
endmodule